// File: doc/BRIEF.md
# Reconfigurable Lookup Cell with Bypass and Gene Shift

This block is a single cell of a chain of identical cells that can repair itself. The cell stores a configuration word, called the gene, in two halves. The low half is the working half. It sets a four-input lookup function, the routing of each lookup input from a 16-wide source vector, the cell state and whether the output is registered. The high half is a backup copy. A repair controller moves configurations one position down the chain. On a shift command the cell takes the backup half of its upstream neighbour into both of its own halves at once. Its own backup half is always presented to the downstream neighbour.

A cell whose gene is all zero is idle and drives 0. A working cell drives either the lookup result or that result delayed through a rising-edge flip-flop. A transparent cell behaves as a wire and forwards the source picked by its first selector. The gene has no reset, so reset clears only the output flip-flop.

Top module: `lut_cell`

## Requirements
- R1: While `load_i` is high, the full 68-bit `gene_i` is written into the gene at the rising clock edge. `shift_gene_o` then shows bits 67:34 of the loaded word.
- R2: Working-half layout: bits 15:0 are the truth table, bits 19:16, 23:20, 27:24 and 31:28 are selectors 0 to 3, bit 32 is the state (1 = working, 0 = transparent) and bit 33 is the delay select. In a working cell with delay select 0, `out_o` = truth_table[{src[sel3], src[sel2], src[sel1], src[sel0]}], combinationally.
- R3: With delay select 1, `out_o` shows the lookup value sampled at the most recent rising clock edge.
- R4: An asynchronous low `rst_ni` clears the output flip-flop at once and leaves the stored gene unchanged.
- R5: A transparent cell (gene nonzero, bit 32 = 0) drives `out_o` = `src_i[sel0]`, whatever its truth table and delay select are.
- R6: A cell whose gene is all zero is idle: `out_o` is 0 and `state_o` is 0.
- R7: When `shift_i` is high and `load_i` is low, the gene becomes {`shift_gene_i`, `shift_gene_i`} at the rising edge, and the new working half takes effect.
- R8: When `load_i` is low, `cmd_i` = 1 clears bit 32 (transparent) and `cmd_i` = 2 sets it (working) at the edge. Codes 0 and 3 leave the state unchanged.
- R9: Priority is load first, then shift, then the state command. A load ignores any shift and command in the same cycle. A command in the same cycle as a shift is applied to the state bit of the shifted-in gene. With neither load nor shift, the gene bits other than the state bit hold.
- R10: `state_o` encodes 0 = idle, 1 = working, 2 = transparent. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the output flip-flop |
| load_i | input | 1 | Gene load strobe |
| gene_i | input | 68 | Gene word to load |
| shift_i | input | 1 | Chain shift enable |
| shift_gene_i | input | 34 | Backup half of the upstream cell |
| cmd_i | input | 2 | State command: 0 keep, 1 transparent, 2 working, 3 keep |
| src_i | input | 16 | Source vector for the lookup inputs |
| out_o | output | 1 | Cell output |
| shift_gene_o | output | 34 | Backup half sent to the downstream cell |
| state_o | output | 2 | State report |

## Verification
A state command and a chain shift can arrive in the same cycle. In that case the command must act on the state bit of the gene that is being shifted in. A load that coincides with either one must override both. The bench drives these pairs on a single edge. It shifts in a working configuration together with a transparent command, then checks that `state_o` reads transparent and that `out_o` follows selector 0 of the new gene. It also loads while shifting and commanding, then checks that `shift_gene_o` and `state_o` come from the loaded word alone.

// File: rtl/cell_pkg.sv
package cell_pkg;
  typedef enum logic [1:0] {
    CELL_IDLE = 2'd0,
    CELL_WORK = 2'd1,
    CELL_THRU = 2'd2
  } cell_state_e;

  typedef enum logic [1:0] {
    CMD_KEEP = 2'd0,
    CMD_THRU = 2'd1,
    CMD_WORK = 2'd2,
    CMD_RSVD = 2'd3
  } cell_cmd_e;
endpackage

// File: rtl/cell_gene_store.sv
module cell_gene_store
  import cell_pkg::*;
#(
  parameter int HALF_W = 34,
  parameter int ST_BIT = 32,
  localparam int GENE_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              load_i,
  input  logic [GENE_W-1:0] gene_i,
  input  logic              shift_i,
  input  logic [HALF_W-1:0] shift_gene_i,
  input  cell_cmd_e         cmd_i,
  output logic [GENE_W-1:0] gene_o
);
  logic [GENE_W-1:0] gene_q, gene_d;

  always_comb begin
    if (load_i) begin
      gene_d = gene_i;
    end else begin
      gene_d = shift_i ? {shift_gene_i, shift_gene_i} : gene_q;
      // command acts on top of a shifted-in gene
      unique case (cmd_i)
        CMD_THRU: gene_d[ST_BIT] = 1'b0;
        CMD_WORK: gene_d[ST_BIT] = 1'b1;
        default:  ;
      endcase
    end
  end

  // gene survives reset by intent
  always_ff @(posedge clk_i) gene_q <= gene_d;

  assign gene_o = gene_q;
endmodule

// File: rtl/cell_lut_eval.sv
module cell_lut_eval #(
  parameter int N_SRC  = 16,
  parameter int LUT_IN = 4,
  localparam int SEL_W  = $clog2(N_SRC),
  localparam int SELS_W = LUT_IN * SEL_W,
  localparam int TT_W   = 1 << LUT_IN
) (
  input  logic [N_SRC-1:0]  src_i,
  input  logic [SELS_W-1:0] sel_i,
  input  logic [TT_W-1:0]   tt_i,
  output logic              lut_o,
  output logic              pass_o
);
  logic [LUT_IN-1:0] idx;

  for (genvar k = 0; k < LUT_IN; k++) begin : g_pick
    assign idx[k] = src_i[sel_i[k*SEL_W +: SEL_W]];
  end

  assign lut_o  = tt_i[idx];
  assign pass_o = idx[0];
endmodule

// File: rtl/cell_out_stage.sv
module cell_out_stage
  import cell_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        lut_i,
  input  logic        pass_i,
  input  logic        dly_i,
  input  cell_state_e state_i,
  output logic        out_o
);
  logic lut_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lut_q <= 1'b0;
    else         lut_q <= lut_i;
  end

  always_comb begin
    unique case (state_i)
      CELL_WORK: out_o = dly_i ? lut_q : lut_i;
      CELL_THRU: out_o = pass_i;
      default:   out_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import cell_pkg::*;
#(
  parameter int N_SRC  = 16,
  parameter int LUT_IN = 4,
  localparam int SEL_W   = $clog2(N_SRC),
  localparam int SELS_W  = LUT_IN * SEL_W,
  localparam int TT_W    = 1 << LUT_IN,
  localparam int ST_BIT  = TT_W + SELS_W,
  localparam int DLY_BIT = ST_BIT + 1,
  localparam int HALF_W  = DLY_BIT + 1,
  localparam int GENE_W  = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [GENE_W-1:0] gene_i,
  input  logic              shift_i,
  input  logic [HALF_W-1:0] shift_gene_i,
  input  logic [1:0]        cmd_i,
  input  logic [N_SRC-1:0]  src_i,
  output logic              out_o,
  output logic [HALF_W-1:0] shift_gene_o,
  output logic [1:0]        state_o
);
  logic [GENE_W-1:0] gene;
  logic              lut_val, pass_val;
  cell_state_e       cell_st;

  cell_gene_store #(.HALF_W(HALF_W), .ST_BIT(ST_BIT)) u_gene (
    .clk_i       (clk_i),
    .load_i      (load_i),
    .gene_i      (gene_i),
    .shift_i     (shift_i),
    .shift_gene_i(shift_gene_i),
    .cmd_i       (cell_cmd_e'(cmd_i)),
    .gene_o      (gene)
  );

  cell_lut_eval #(.N_SRC(N_SRC), .LUT_IN(LUT_IN)) u_eval (
    .src_i (src_i),
    .sel_i (gene[TT_W +: SELS_W]),
    .tt_i  (gene[TT_W-1:0]),
    .lut_o (lut_val),
    .pass_o(pass_val)
  );

  always_comb begin
    if (gene == '0)        cell_st = CELL_IDLE;
    else if (gene[ST_BIT]) cell_st = CELL_WORK;
    else                   cell_st = CELL_THRU;
  end

  cell_out_stage u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lut_i  (lut_val),
    .pass_i (pass_val),
    .dly_i  (gene[DLY_BIT]),
    .state_i(cell_st),
    .out_o  (out_o)
  );

  assign shift_gene_o = gene[GENE_W-1:HALF_W];
  assign state_o      = cell_st;
endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk #(
  parameter int HALF_W = 34
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [HALF_W-1:0] gene_hi_i,
  input logic              shift_i,
  input logic [HALF_W-1:0] shift_gene_i,
  input logic [1:0]        cmd_i,
  input logic              out_o,
  input logic [HALF_W-1:0] shift_gene_o,
  input logic [1:0]        state_o
);
  p_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> shift_gene_o == $past(gene_hi_i));

  p_shift_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && shift_i) |=> shift_gene_o == $past(shift_gene_i));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(shift_gene_o));

  p_cmd_thru_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cmd_i == 2'd1) |=> state_o != 2'd1);

  p_cmd_work_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cmd_i == 2'd2) |=> state_o == 2'd1);

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd0 |-> !out_o);

  p_state_code_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd3);
endmodule

bind lut_cell lut_cell_chk #(.HALF_W(HALF_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_i      (load_i),
  .gene_hi_i   (gene_i[GENE_W-1:HALF_W]),
  .shift_i     (shift_i),
  .shift_gene_i(shift_gene_i),
  .cmd_i       (cmd_i),
  .out_o       (out_o),
  .shift_gene_o(shift_gene_o),
  .state_o     (state_o)
);

// File: tb/tb_lut_cell.sv
module tb_lut_cell;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [67:0] gene_i = '0;
  logic        shift_i = 1'b0;
  logic [33:0] shift_gene_i = '0;
  logic [1:0]  cmd_i = 2'd0;
  logic [15:0] src_i = '0;
  logic        out_o;
  logic [33:0] shift_gene_o;
  logic [1:0]  state_o;

  int n_run = 0;
  int n_bad = 0;

  lut_cell dut (.*);

  always #2 clk_i = ~clk_i;

  function automatic logic [33:0] mk_half(input logic [15:0] tt, input logic [3:0] s0, s1, s2, s3,
                                          input logic st, dly);
    return {dly, st, s3, s2, s1, s0, tt};
  endfunction

  function automatic logic exp_lut(input logic [33:0] h, input logic [15:0] src);
    logic [3:0] idx;
    for (int k = 0; k < 4; k++) idx[k] = src[h[16+4*k +: 4]];
    return h[idx];
  endfunction

  task automatic check(input string req, input logic [67:0] act, input logic [67:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_gene(input logic [67:0] g);
    @(negedge clk_i);
    load_i = 1'b1; gene_i = g;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [33:0] h, b, h1;
    logic        prev;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R6 idle gene
    load_gene('0);
    src_i = 16'hFFFF; #1;
    check("R6 idle out", out_o, 0);
    check("R6 idle state", state_o, 0);

    // R2 straight selectors, several truth tables
    foreach (gene_i[i]) ;
    for (int t = 0; t < 3; t++) begin
      logic [15:0] tt;
      tt = (t == 0) ? 16'h8000 : (t == 1) ? 16'h6996 : 16'hCAFE;
      h = mk_half(tt, 4'd0, 4'd1, 4'd2, 4'd3, 1'b1, 1'b0);
      load_gene({34'h0, h});
      check("R10 working code", state_o, 1);
      for (int v = 0; v < 16; v++) begin
        @(negedge clk_i); src_i = 16'(v); #1;
        check("R2 lut straight", out_o, tt[v]);
      end
    end

    // R2 scrambled selectors
    h = mk_half(16'h1E5A, 4'd15, 4'd8, 4'd4, 4'd1, 1'b1, 1'b0);
    load_gene({34'h0, h});
    for (int v = 0; v < 64; v++) begin
      @(negedge clk_i); src_i = 16'(v * 16'h3A9D + 16'h1234); #1;
      check("R2 lut scrambled", out_o, exp_lut(h, src_i));
    end

    // R3 registered output
    b = mk_half(16'h0F0F, 4'd3, 4'd2, 4'd1, 4'd0, 1'b1, 1'b1);
    h = mk_half(16'h6996, 4'd0, 4'd1, 4'd2, 4'd3, 1'b1, 1'b1);
    load_gene({b, h});
    @(negedge clk_i); src_i = 16'd0;
    @(negedge clk_i);
    prev = 1'b0;
    for (int v = 1; v < 16; v++) begin
      src_i = 16'(v); #1;
      check("R3 before edge", out_o, prev);
      @(negedge clk_i);
      check("R3 after edge", out_o, exp_lut(h, 16'(v)));
      prev = exp_lut(h, 16'(v));
    end

    // R4 reset clears flop, keeps gene
    src_i = 16'd1;
    @(negedge clk_i);
    check("R4 flop set", out_o, 1);
    rst_ni = 1'b0; #1;
    check("R4 async clear", out_o, 0);
    @(negedge clk_i); rst_ni = 1'b1; #1;
    check("R4 gene kept", shift_gene_o, b);
    check("R4 state kept", state_o, 1);
    @(negedge clk_i);
    check("R4 flop resumes", out_o, 1);

    // R5 transparent follows selector 0
    h = mk_half(16'hFFFF, 4'd9, 4'd1, 4'd2, 4'd3, 1'b1, 1'b1);
    load_gene({34'h0, h});
    @(negedge clk_i); cmd_i = 2'd1;
    @(negedge clk_i); cmd_i = 2'd0;
    check("R8 to transparent", state_o, 2);
    for (int k = 0; k < 16; k++) begin
      src_i = 16'(1) << k; #1;
      check("R5 pass one-hot", out_o, (k == 9));
      src_i = ~src_i; #1;
      check("R5 pass inverted", out_o, (k != 9));
      @(negedge clk_i);
    end

    // R8 reserved code holds, then back to working
    cmd_i = 2'd3;
    @(negedge clk_i); cmd_i = 2'd0;
    check("R8 code 3 keeps", state_o, 2);
    cmd_i = 2'd2;
    @(negedge clk_i); cmd_i = 2'd0;
    check("R8 to working", state_o, 1);

    // R7 shift from upstream
    b  = mk_half(16'h8000, 4'd0, 4'd1, 4'd2, 4'd3, 1'b1, 1'b0);
    h1 = mk_half(16'hFFFE, 4'd0, 4'd1, 4'd2, 4'd3, 1'b1, 1'b0);
    load_gene({b, b});
    @(negedge clk_i); shift_i = 1'b1; shift_gene_i = h1;
    @(negedge clk_i); shift_i = 1'b0;
    check("R7 backup forwarded", shift_gene_o, h1);
    src_i = 16'd0; #1;
    check("R7 new function 0", out_o, 0);
    src_i = 16'd2; #1;
    check("R7 new function 1", out_o, 1);

    // R9 shift and command in one cycle
    @(negedge clk_i); shift_i = 1'b1; shift_gene_i = h1; cmd_i = 2'd1;
    @(negedge clk_i); shift_i = 1'b0; cmd_i = 2'd0;
    check("R9 shift+cmd state", state_o, 2);
    check("R9 shift+cmd gene", shift_gene_o, h1);
    src_i = 16'd2; #1;
    check("R9 shift+cmd pass", out_o, 0);
    src_i = 16'd1; #1;
    check("R9 shift+cmd pass 1", out_o, 1);

    // R9 load beats shift and command
    @(negedge clk_i);
    load_i = 1'b1; gene_i = {b, h1}; shift_i = 1'b1; shift_gene_i = 34'h0; cmd_i = 2'd1;
    @(negedge clk_i);
    load_i = 1'b0; shift_i = 1'b0; cmd_i = 2'd0;
    check("R9 load wins gene", shift_gene_o, b);
    check("R9 load wins state", state_o, 1);
    check("R1 loaded backup", shift_gene_o, b);

    // R7/R6 shifting in an empty gene makes the cell idle
    @(negedge clk_i); shift_i = 1'b1; shift_gene_i = 34'h0;
    @(negedge clk_i); shift_i = 1'b0;
    src_i = 16'hFFFF; #1;
    check("R7 shift to idle", state_o, 0);
    check("R6 idle after shift", out_o, 0);

    finish_run();
  end
endmodule